// File: doc/BRIEF.md
# JTAG Job-Register Bridge

This block is a slave that hangs off a test-access-port user instruction. A host shifts serial frames through the data-register path; the bridge decodes each complete frame into either a write of a 32-bit word or a request to read one. The decoded writes fill a small register file holding the input words of a compute job and a clock-multiplier setting. A read request does not return data at once: the requested word is loaded at the next capture and leaves on `tdo` during the following scan.

One address is a result port. Reading it removes the oldest entry of a 16-entry queue that the compute core fills through a push port. An empty queue answers with all ones, so the host can drain the queue by reading until that value appears. Writing the last job word emits a one-cycle start pulse. Every frame carries a direction flag and an odd-parity bit. A frame with a bad flag, bad parity or the wrong length leaves all state untouched.

The TAP strobes are clock enables sampled on the block clock. The block acts on them only while the instruction register holds the user code.

Top module: `jtag_job_bridge`

## Requirements
- R1: The capture, shift and update strobes act only while `ir_value` equals the parameter `USER_IR` (default 6'h02). With any other value, no register, queue or output changes.
- R2: A write frame is 38 bits, counted in shift order from the first bit. Bits 0-31 are data (bit 0 first), bits 32-35 are the address (LSB first), bit 36 is the direction flag and must be 1, and bit 37 is parity. The word is written at the update strobe.
- R3: A read request is a 6-bit frame: address bits 0-3, flag bit 4 equal to 0, and parity bit 5. The following capture loads the addressed word. `tdo` then shows bit 0, and each shift strobe advances `tdo` to the next bit.
- R4: The parity bit makes the number of ones in the whole frame odd. A frame with even parity is discarded.
- R5: A frame is decoded only when the number of shift strobes since the last capture is exactly 38 or 6. A 38-bit frame whose flag is 0, or a 6-bit frame whose flag is 1, is discarded.
- R6: Addresses 1-8 hold state words and addresses 9-10 hold message words. The word at address a appears on `job_words[32*(a-1) +: 32]` after the write.
- R7: A write to address 11 stores the final message word at `job_words[351:320]`. It also raises `job_start` for exactly one cycle, in the cycle after the update strobe. Writes to other addresses leave `job_start` low.
- R8: Address 13 holds the clock multiplier. It drives `clk_mult` and reads back as written.
- R9: A read of address 14 pops the oldest queue entry at the capture strobe. When the queue is empty, the read returns 32'hFFFFFFFF and the queue stays empty.
- R10: The queue holds 16 entries in first-in first-out order. A push to a full queue with no pop in the same cycle is dropped, and it sets `res_ovf`, which stays set until reset.
- R11: Reads of unmapped addresses 0, 12 and 15 return zero and do not disturb the queue.
- R12: After reset, `job_words`, `clk_mult`, `job_start`, `tdo` and `res_ovf` are zero and the queue is empty.
- R13: A push and a pop in the same cycle both take effect. On a full queue the push is accepted without overflow. On an empty queue the read returns all ones and the pushed entry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ir_value | input | 6 | Current instruction register contents |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe, one bit per cycle |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| job_words | output | 352 | Eleven job words, address 1 in the low word |
| job_start | output | 1 | One-cycle pulse after a write to address 11 |
| clk_mult | output | 32 | Clock-multiplier register |
| res_push | input | 1 | Push a result into the queue |
| res_data | input | 32 | Result word to push |
| res_ovf | output | 1 | Sticky flag for a push dropped on a full queue |

## Verification
Two events can land in the same cycle: the compute core pushing a result, and a capture strobe popping the queue for a result read. The bench raises `res_push` on the exact cycle of the capture. It does this once with the queue full and once with it empty. In the full case it expects the oldest entry back, no overflow, and sixteen entries left in order. In the empty case it expects all ones back, with the pushed word returned by the next read.

// File: rtl/jbr_pkg.sv
package jbr_pkg;
  localparam int ADDR_W      = 4;
  localparam int RD_LEN      = ADDR_W + 2;
  localparam int NJOB_WORDS  = 11;
  localparam int A_JOB_FIRST = 1;
  localparam int A_JOB_LAST  = A_JOB_FIRST + NJOB_WORDS - 1;
  localparam int A_MULT      = 13;
  localparam int A_RESULT    = 14;
endpackage

// File: rtl/jbr_frame.sv
module jbr_frame
  import jbr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  input  logic [DATA_W-1:0] load_val,
  output logic              tdo,
  output logic              wr_en,
  output logic              rd_req,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_data
);
  localparam int FL      = DATA_W + ADDR_W + 2;
  localparam int CW      = $clog2(FL + 2);
  localparam int CNT_BAD = FL + 1;

  logic [FL-1:0] sr;
  logic [CW-1:0] cnt;
  logic          flag, long_ok, short_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= CW'(CNT_BAD);
    end else if (sel) begin
      if (capture) begin
        sr  <= {{(FL-DATA_W){1'b0}}, load_val};
        cnt <= '0;
      end else if (shift) begin
        sr <= {tdi, sr[FL-1:1]};
        if (cnt != CW'(CNT_BAD)) cnt <= cnt + CW'(1);
      end else if (update) begin
        cnt <= CW'(CNT_BAD);
      end
    end
  end

  assign tdo    = sr[0];
  assign f_data = sr[DATA_W-1:0];
  assign f_addr = sr[DATA_W +: ADDR_W];
  assign flag   = sr[DATA_W + ADDR_W];

  always_comb begin
    long_ok  = (cnt == CW'(FL)) && (^sr) && flag;
    short_ok = (cnt == CW'(RD_LEN)) && (^sr[FL-1 -: RD_LEN]) && !flag;
    wr_en    = sel && update && long_ok;
    rd_req   = sel && update && short_ok;
  end
endmodule

// File: rtl/jbr_fifo.sv
module jbr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, accept, do_pop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign do_pop = pop && !empty;
  assign accept = push && (!full || do_pop);
  assign dout   = empty ? '1 : mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (accept) wr_ptr <= nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      case ({accept, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (push && !accept) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/jbr_regs.sv
module jbr_regs
  import jbr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_req,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         capture_sel,
  input  logic [DATA_W-1:0]            q_dout,
  output logic                         q_pop,
  output logic [DATA_W-1:0]            load_val,
  output logic [NJOB_WORDS*DATA_W-1:0] job_words,
  output logic                         job_start,
  output logic [DATA_W-1:0]            clk_mult
);
  logic [DATA_W-1:0] job [NJOB_WORDS];
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr;

  for (genvar i = 0; i < NJOB_WORDS; i++) begin : g_job
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(A_JOB_FIRST + i);
    always_ff @(posedge clk) begin
      if (rst)                         job[i] <= '0;
      else if (wr_en && addr == MY_A)  job[i] <= wdata;
    end
    assign job_words[i*DATA_W +: DATA_W] = job[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_mult  <= '0;
      job_start <= 1'b0;
      rd_pend   <= 1'b0;
      rd_addr   <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(A_MULT)) clk_mult <= wdata;
      job_start <= wr_en && (addr == ADDR_W'(A_JOB_LAST));
      if (capture_sel) begin
        rd_pend <= 1'b0;
      end else if (rd_req) begin
        rd_pend <= 1'b1;
        rd_addr <= addr;
      end
    end
  end

  always_comb begin
    load_val = '0;
    if (rd_pend) begin
      for (int i = 0; i < NJOB_WORDS; i++)
        if (rd_addr == ADDR_W'(A_JOB_FIRST + i)) load_val = job[i];
      if (rd_addr == ADDR_W'(A_MULT))   load_val = clk_mult;
      if (rd_addr == ADDR_W'(A_RESULT)) load_val = q_dout;
    end
  end

  assign q_pop = capture_sel && rd_pend && (rd_addr == ADDR_W'(A_RESULT));
endmodule

// File: rtl/jtag_job_bridge.sv
module jtag_job_bridge
  import jbr_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          FIFO_DEPTH = 16,
  parameter logic [5:0]  USER_IR    = 6'h02,
  localparam int         JW         = NJOB_WORDS * DATA_W,
  localparam int         QCW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        ir_value,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic [JW-1:0]     job_words,
  output logic              job_start,
  output logic [DATA_W-1:0] clk_mult,
  input  logic              res_push,
  input  logic [DATA_W-1:0] res_data,
  output logic              res_ovf
);
  logic              sel;
  logic              wr_en, rd_req, q_pop;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data, load_val, q_dout;
  logic [QCW-1:0]    q_count;

  assign sel = (ir_value == USER_IR);

  jbr_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .sel(sel),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr),
    .tdi(tdi), .load_val(load_val), .tdo(tdo),
    .wr_en(wr_en), .rd_req(rd_req), .f_addr(f_addr), .f_data(f_data)
  );

  jbr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_req(rd_req),
    .addr(f_addr), .wdata(f_data), .capture_sel(sel && capture_dr),
    .q_dout(q_dout), .q_pop(q_pop), .load_val(load_val),
    .job_words(job_words), .job_start(job_start), .clk_mult(clk_mult)
  );

  jbr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(res_push), .din(res_data),
    .pop(q_pop), .dout(q_dout), .count(q_count), .ovf(res_ovf)
  );
endmodule

// File: rtl/jbr_checker.sv
module jbr_checker #(
  parameter int DATA_W = 32,
  parameter int JW     = 352,
  parameter int DEPTH  = 16,
  parameter int QCW    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              update_dr,
  input logic              job_start,
  input logic [DATA_W-1:0] clk_mult,
  input logic [JW-1:0]     job_words,
  input logic              res_push,
  input logic              res_ovf,
  input logic [QCW-1:0]    q_count,
  input logic              q_pop
);
  p_unselected_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !sel |=> ($stable(clk_mult) && $stable(job_words)));

  p_start_single_r7: assert property (@(posedge clk) disable iff (rst)
    job_start |=> !job_start);

  p_start_from_update_r7: assert property (@(posedge clk) disable iff (rst)
    job_start |-> $past(update_dr && sel));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (q_count == '0 && q_pop && !res_push) |=> (q_count == '0));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    q_count <= QCW'(DEPTH));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    res_ovf |=> res_ovf);

  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(res_ovf) |-> $past(res_push && q_count == QCW'(DEPTH)));
endmodule

bind jtag_job_bridge jbr_checker #(
  .DATA_W(DATA_W), .JW(JW), .DEPTH(FIFO_DEPTH), .QCW(QCW)
) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .update_dr(update_dr),
  .job_start(job_start), .clk_mult(clk_mult), .job_words(job_words),
  .res_push(res_push), .res_ovf(res_ovf), .q_count(q_count), .q_pop(q_pop)
);

// File: tb/jtag_job_bridge_test.sv
module jtag_job_bridge_test;
  logic         clk = 0, rst = 1;
  logic [5:0]   ir_value = 6'h02;
  logic         capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic         tdo, job_start, res_ovf;
  logic [351:0] job_words;
  logic [31:0]  clk_mult;
  logic         res_push = 0;
  logic [31:0]  res_data = 0;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mj [16];
  logic [31:0] mmult;
  logic [31:0] mq [$];

  always #5 clk = ~clk;

  jtag_job_bridge uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] wr_frame(logic [3:0] a, logic [31:0] d);
    logic [37:0] f;
    f[31:0] = d; f[35:32] = a; f[36] = 1'b1; f[37] = ~(^f[36:0]);
    return {26'b0, f};
  endfunction

  function automatic logic [63:0] rd_frame(logic [3:0] a);
    logic [5:0] f;
    f[3:0] = a; f[4] = 1'b0; f[5] = ~(^f[4:0]);
    return {58'b0, f};
  endfunction

  task automatic scan(input logic [63:0] din, input int n, input logic pe,
                      input logic [31:0] pd, output logic [63:0] dout);
    @(negedge clk); capture_dr = 1; res_push = pe; res_data = pd;
    @(negedge clk); capture_dr = 0; res_push = 0; dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo; tdi = din[i]; shift_dr = 1;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk); update_dr = 0;
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d);
    logic [63:0] junk;
    scan(wr_frame(a, d), 38, 1'b0, 32'h0, junk);
    if (a >= 1 && a <= 11) mj[a] = d;
    if (a == 13) mmult = d;
  endtask

  task automatic do_read(logic [3:0] a, logic pe, logic [31:0] pd, output logic [31:0] d);
    logic [63:0] o;
    scan(rd_frame(a), 6, 1'b0, 32'h0, o);
    scan(64'h0, 32, pe, pd, o);
    d = o[31:0];
  endtask

  task automatic push(logic [31:0] d);
    @(negedge clk); res_push = 1; res_data = d;
    @(negedge clk); res_push = 0;
    if (mq.size() < 16) mq.push_back(d);
  endtask

  function automatic logic [31:0] model_read(logic [3:0] a);
    if (a >= 1 && a <= 11) return mj[a];
    if (a == 13) return mmult;
    return 32'h0;
  endfunction

  task automatic read_result(string req, logic pe, logic [31:0] pd);
    logic [31:0] got, exp;
    do_read(4'd14, pe, pd, got);
    exp = (mq.size() == 0) ? 32'hFFFFFFFF : mq.pop_front();
    if (pe && mq.size() < 16) mq.push_back(pd);
    check(req, {32'h0, got}, {32'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [63:0] fr, junk;
    void'($urandom(32'd7031));
    for (int i = 0; i < 16; i++) mj[i] = 0;
    mmult = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R12 reset state
    check("R12 job_words", {63'h0, |job_words}, 64'h0);
    check("R12 clk_mult", {32'h0, clk_mult}, 64'h0);
    check("R12 outputs", {61'h0, job_start, tdo, res_ovf}, 64'h0);

    // R8 / R2 / R3 multiplier write and readback
    do_write(4'd13, 32'd190);
    check("R8 clk_mult", {32'h0, clk_mult}, 64'd190);
    do_read(4'd13, 0, 0, got);
    check("R3 readback mult", {32'h0, got}, 64'd190);

    // R6 state and message words
    for (int a = 1; a <= 10; a++) do_write(4'(a), 32'hA5000000 + 32'(a * 257));
    check("R7 no start on word 10", {63'h0, job_start}, 64'h0);
    for (int a = 1; a <= 10; a++)
      check("R6 job word", {32'h0, job_words[32*(a-1) +: 32]}, {32'h0, mj[a]});

    // R7 start pulse
    do_write(4'd11, 32'hDEADBEEF);
    check("R7 start high", {63'h0, job_start}, 64'h1);
    check("R7 final word", {32'h0, job_words[351:320]}, 64'hDEADBEEF);
    @(negedge clk);
    check("R7 start single", {63'h0, job_start}, 64'h0);

    // R4 bad parity
    fr = wr_frame(4'd13, 32'h1234);
    fr[37] = ~fr[37];
    scan(fr, 38, 0, 0, junk);
    check("R4 bad parity ignored", {32'h0, clk_mult}, {32'h0, mmult});

    // R5 wrong lengths and flags
    scan(wr_frame(4'd13, 32'h55), 37, 0, 0, junk);
    check("R5 length 37 ignored", {32'h0, clk_mult}, {32'h0, mmult});
    scan(wr_frame(4'd13, 32'h66), 39, 0, 0, junk);
    check("R5 length 39 ignored", {32'h0, clk_mult}, {32'h0, mmult});
    fr = wr_frame(4'd13, 32'h77);
    fr[36] = 0; fr[37] = ~fr[37];
    scan(fr, 38, 0, 0, junk);
    check("R5 flag zero ignored", {32'h0, clk_mult}, {32'h0, mmult});

    // R1 not selected
    ir_value = 6'h3F;
    scan(wr_frame(4'd13, 32'h99), 38, 0, 0, junk);
    ir_value = 6'h02;
    check("R1 unselected ignored", {32'h0, clk_mult}, {32'h0, mmult});

    // R9 empty read, R11 unmapped reads do not pop
    read_result("R9 empty all ones", 0, 0);
    push(32'hCAFE0001);
    do_read(4'd0, 0, 0, got);  check("R11 addr 0",  {32'h0, got}, 64'h0);
    do_read(4'd12, 0, 0, got); check("R11 addr 12", {32'h0, got}, 64'h0);
    do_read(4'd15, 0, 0, got); check("R11 addr 15", {32'h0, got}, 64'h0);
    read_result("R11 queue kept", 0, 0);
    read_result("R9 empty again", 0, 0);

    // R13 empty pop with simultaneous push
    read_result("R13 empty pop+push", 1, 32'hBEE00001);
    read_result("R13 pushed kept", 0, 0);

    // R13 full pop with simultaneous push
    for (int i = 0; i < 16; i++) push($urandom);
    read_result("R13 full pop+push", 1, 32'hF00DF00D);
    check("R13 no overflow", {63'h0, res_ovf}, 64'h0);
    for (int i = 0; i < 16; i++) read_result("R10 order", 0, 0);
    read_result("R9 drained", 0, 0);

    // R10 overflow
    for (int i = 0; i < 16; i++) push($urandom);
    push(32'h0BAD0BAD);
    check("R10 ovf set", {63'h0, res_ovf}, 64'h1);
    for (int i = 0; i < 16; i++) read_result("R10 drop kept order", 0, 0);
    read_result("R10 drained", 0, 0);
    check("R10 ovf sticky", {63'h0, res_ovf}, 64'h1);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int op, r;
      logic [3:0] a;
      op = $urandom_range(0, 3);
      r = $urandom_range(0, 11);
      a = (r < 11) ? 4'(r + 1) : 4'd13;
      case (op)
        0: do_write(a, $urandom);
        1: begin
          do_read(a, 0, 0, got);
          check("R3 random read", {32'h0, got}, {32'h0, model_read(a)});
        end
        2: if (mq.size() < 16) push($urandom);
        default: read_result("R9 random pop", 0, 0);
      endcase
    end
    for (int a = 1; a <= 11; a++)
      check("R6 final word", {32'h0, job_words[32*(a-1) +: 32]}, {32'h0, mj[a]});
    check("R8 final mult", {32'h0, clk_mult}, {32'h0, mmult});

    // R12 reset clears sticky state
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R12 ovf after reset", {63'h0, res_ovf}, 64'h0);
    mq.delete();
    read_result("R12 queue empty after reset", 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule